// File: doc/BRIEF.md
# Indirect Register Access Port

This block lets a host reach an internal bank of registers through a window of six directly addressed registers. The window holds an indirect address register, four 16-bit data registers and a status register. Writing the address register starts one internal transaction. Bit 7 of the written address picks the direction (1 = read, 0 = write). Bits 6:1 pick the internal register index. For reads, bit 0 picks the upper half of the 32-bit register.

A transaction takes a fixed number of cycles. During that time the status register reports busy, and software polls it until busy clears. A read places the selected 16-bit half into data register 0. A write stores data register 1 as the upper half and data register 0 as the lower half of the addressed register. A bit set or bit clear is done in software as a read, then an update of data register 0, then a write.

The status register also holds two active-low reset controls, one global and one for the codec. Writing 0 to the status register asserts both resets.

Top module: `ind_reg_port`

## Requirements
- R1: After rst_ni, every window offset reads 0, and glob_rst_no and codec_rst_no are both low.
- R2: The status register is at offset 0. Bit 1 drives glob_rst_no and bit 2 drives codec_rst_no, starting the cycle after the write. Writing 0 asserts both resets. Bit 0 is read-only.
- R3: Offset 1 is the address register. Writing it while idle and with the global reset released starts a transaction. Status bit 0 then reads 1 for exactly BUSY_CYCLES cycles (default 4) and afterwards reads 0.
- R4: An address with bit 7 set is a read of register index bits 6:1. When busy clears, data register 0 (offset 2) holds the low half of that register if bit 0 is clear, or the high half if bit 0 is set.
- R5: An address with bit 7 clear is a write. When the transaction ends, the indexed register holds {data1[15:0], data0[15:0]}, where data1 is at offset 3. Bit 0 of the address has no effect on a write.
- R6: While busy, host writes to the address register and to the data registers are ignored. The address readback, the data registers and the busy length stay as if those writes never happened.
- R7: Data registers (offsets 2 to 5) keep only the low 16 bits of a host write and read back zero-extended. Offsets 4 and 5 never affect a transaction.
- R8: A write to an index of NREG (default 16) or above changes no register. A read of such an index returns 0.
- R9: While the global reset is asserted, address writes start nothing and the internal registers are held cleared. Asserting the global reset during a transaction cancels it, and busy reads 0 the next cycle.
- R10: A read, then an update of data register 0, then a write of the same index changes only the intended bits of that register.
- R11: Offsets 6 and 7 read 0 and ignore writes. The address register reads back the last accepted 8-bit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe, one cycle per write |
| host_addr_i | input | 3 | Window offset for host reads and writes |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Combinational read data of the selected offset |
| glob_rst_no | output | 1 | Global reset, active low |
| codec_rst_no | output | 1 | Codec reset, active low |

## Verification
The bench tries three traffic patterns against a behavioural model that it compares on every clock.

- **Well-behaved sequences.** Full 32-bit writes followed by low-half and high-half reads show whether the half select and the data register pairing are right.
- **Writes while busy.** Address and data writes issued during the busy window show whether launches and operand changes are correctly locked out.
- **Reset and range cases.** Asserting the global reset mid-transaction, and addressing indices past the bank, separate cancellation and clearing from normal completion.

A read-modify-write of single bits checks that the three-step sequence touches only the intended bit.

// File: rtl/irp_pkg.sv
`timescale 1ns/1ps
package irp_pkg;
  localparam int HOST_AW = 3;
  localparam int HOST_DW = 32;
  localparam int HALF_W  = 16;
  localparam int NDATA   = 4;

  localparam logic [HOST_AW-1:0] OFF_STAT  = 3'd0;
  localparam logic [HOST_AW-1:0] OFF_IADDR = 3'd1;
  localparam logic [HOST_AW-1:0] OFF_DATA0 = 3'd2;

  localparam int ST_BUSY   = 0;
  localparam int ST_GRST_N = 1;
  localparam int ST_CRST_N = 2;

  // indirect address layout: direction, register index, half select
  typedef struct packed {
    logic       rd;
    logic [5:0] idx;
    logic       hi;
  } iaddr_t;
endpackage

// File: rtl/irp_seq.sv
`timescale 1ns/1ps
module irp_seq #(
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1)) && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (abort_i)  cnt_q <= '0;
    else if (launch_i) cnt_q <= CW'(BUSY_CYCLES);
    else if (busy_o)   cnt_q <= cnt_q - CW'(1);
  end

  AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i && !abort_i |=> busy_o); // R3
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R3
  AST_BUSY_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && !abort_i |=> busy_o); // R3
endmodule

// File: rtl/irp_bank.sv
`timescale 1ns/1ps
module irp_bank #(
  parameter int NREG = 16,
  parameter int DW   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [5:0]    idx_i,
  input  logic          hi_i,
  input  logic [2*DW-1:0] wdata_i,
  output logic [DW-1:0] rhalf_o
);
  localparam int RW = 2 * DW;

  logic [RW-1:0] reg_w [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [RW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (clr_i)                        q <= '0;
      else if (we_i && (idx_i == 6'(g)))     q <= wdata_i;
    end
    assign reg_w[g] = q;
  end

  // indices past NREG match nothing and read as zero
  always_comb begin
    rhalf_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (idx_i == 6'(i)) rhalf_o = hi_i ? reg_w[i][RW-1:DW] : reg_w[i][DW-1:0];
    end
  end

  AST_CLR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rhalf_o == '0)); // R9
endmodule

// File: rtl/irp_window.sv
`timescale 1ns/1ps
module irp_window
  import irp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_wr_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [HOST_DW-1:0] host_wdata_i,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic [HALF_W-1:0]  rhalf_i,
  output logic               launch_o,
  output logic               abort_o,
  output iaddr_t             iaddr_o,
  output logic [2*HALF_W-1:0] wr_word_o,
  output logic               bank_we_o,
  output logic               bank_clr_o,
  output logic [HOST_DW-1:0] host_rdata_o,
  output logic               grst_no,
  output logic               crst_no
);
  logic   grst_n_q, crst_n_q;
  iaddr_t iaddr_q;
  logic [HALF_W-1:0] data_w [NDATA];
  logic wr_stat, wr_iaddr, rd_done;

  assign wr_stat    = host_wr_i && (host_addr_i == OFF_STAT);
  assign wr_iaddr   = host_wr_i && (host_addr_i == OFF_IADDR);
  assign launch_o   = wr_iaddr && !busy_i && grst_n_q;
  assign abort_o    = wr_stat && !host_wdata_i[ST_GRST_N];
  assign rd_done    = done_i && iaddr_q.rd;
  assign bank_we_o  = done_i && !iaddr_q.rd;
  assign bank_clr_o = !grst_n_q;
  assign wr_word_o  = {data_w[1], data_w[0]};
  assign iaddr_o    = iaddr_q;
  assign grst_no    = grst_n_q;
  assign crst_no    = crst_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grst_n_q <= 1'b0;
      crst_n_q <= 1'b0;
    end else if (wr_stat) begin
      grst_n_q <= host_wdata_i[ST_GRST_N];
      crst_n_q <= host_wdata_i[ST_CRST_N];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       iaddr_q <= '0;
    else if (launch_o) iaddr_q <= iaddr_t'(host_wdata_i[7:0]);
  end

  for (genvar g = 0; g < NDATA; g++) begin : g_data
    localparam logic [HOST_AW-1:0] SEL = OFF_DATA0 + HOST_AW'(g);
    logic host_ld;
    logic [HALF_W-1:0] q;
    assign host_ld = host_wr_i && !busy_i && (host_addr_i == SEL);
    if (g == 0) begin : g_rd
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (rd_done) q <= rhalf_i;
        else if (host_ld) q <= host_wdata_i[HALF_W-1:0];
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (host_ld) q <= host_wdata_i[HALF_W-1:0];
      end
    end
    assign data_w[g] = q;
  end

  always_comb begin
    host_rdata_o = '0;
    if (host_addr_i == OFF_STAT)
      host_rdata_o = HOST_DW'({crst_n_q, grst_n_q, busy_i});
    else if (host_addr_i == OFF_IADDR)
      host_rdata_o = HOST_DW'(iaddr_q);
    for (int k = 0; k < NDATA; k++) begin
      if (host_addr_i == OFF_DATA0 + HOST_AW'(k)) host_rdata_o = HOST_DW'(data_w[k]);
    end
  end

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(iaddr_q)); // R6
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(data_w[1])); // R6
  AST_RD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done |=> (data_w[0] == $past(rhalf_i))); // R4
  AST_STAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat && (host_wdata_i[ST_CRST_N:ST_GRST_N] == 2'b00) |=> !grst_no && !crst_no); // R2
endmodule

// File: rtl/ind_reg_port.sv
`timescale 1ns/1ps
module ind_reg_port
  import irp_pkg::*;
#(
  parameter int NREG        = 16,
  parameter int BUSY_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_wr_i,
  input  logic [2:0]  host_addr_i,
  input  logic [31:0] host_wdata_i,
  output logic [31:0] host_rdata_o,
  output logic        glob_rst_no,
  output logic        codec_rst_no
);
  logic   launch, abort, busy, done, bank_we, bank_clr;
  iaddr_t iaddr;
  logic [2*HALF_W-1:0] wr_word;
  logic [HALF_W-1:0]   rhalf;

  irp_window u_window (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_wr_i    (host_wr_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .busy_i       (busy),
    .done_i       (done),
    .rhalf_i      (rhalf),
    .launch_o     (launch),
    .abort_o      (abort),
    .iaddr_o      (iaddr),
    .wr_word_o    (wr_word),
    .bank_we_o    (bank_we),
    .bank_clr_o   (bank_clr),
    .host_rdata_o (host_rdata_o),
    .grst_no      (glob_rst_no),
    .crst_no      (codec_rst_no)
  );

  irp_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .abort_i  (abort),
    .busy_o   (busy),
    .done_o   (done)
  );

  irp_bank #(.NREG(NREG), .DW(HALF_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (bank_clr),
    .we_i    (bank_we),
    .idx_i   (iaddr.idx),
    .hi_i    (iaddr.hi),
    .wdata_i (wr_word),
    .rhalf_o (rhalf)
  );

  AST_BUSY_NEEDS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> glob_rst_no); // R9
endmodule

// File: tb/ind_reg_port_tb_top.sv
`timescale 1ns/1ps
module ind_reg_port_tb_top;
  localparam int NREG = 16;
  localparam int BUSY = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [31:0] host_wdata = 32'd0;
  logic [31:0] host_rdata_o;
  logic        glob_rst_no, codec_rst_no;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ind_reg_port #(.NREG(NREG), .BUSY_CYCLES(BUSY)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .host_wr_i    (host_wr),
    .host_addr_i  (host_addr),
    .host_wdata_i (host_wdata),
    .host_rdata_o (host_rdata_o),
    .glob_rst_no  (glob_rst_no),
    .codec_rst_no (codec_rst_no)
  );

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg [NREG];
  logic [15:0] m_d [4];
  logic [7:0]  m_addr;
  logic        m_g, m_c;
  int          m_cnt;

  task automatic m_reset();
    for (int i = 0; i < NREG; i++) m_reg[i] = 32'd0;
    for (int i = 0; i < 4; i++) m_d[i] = 16'd0;
    m_addr = 8'd0; m_g = 1'b0; m_c = 1'b0; m_cnt = 0;
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] o);
    case (o)
      3'd0: m_read = {29'd0, m_c, m_g, (m_cnt > 0)};
      3'd1: m_read = {24'd0, m_addr};
      3'd2, 3'd3, 3'd4, 3'd5: m_read = {16'd0, m_d[o - 3'd2]};
      default: m_read = 32'd0;
    endcase
  endfunction

  task automatic m_step();
    bit busy, abort, done, launch, pre_g;
    logic [7:0] pa;
    logic [15:0] d0, d1;
    int idx;
    busy   = (m_cnt > 0);
    abort  = host_wr && host_addr == 3'd0 && !host_wdata[1];
    done   = (m_cnt == 1) && !abort;
    launch = host_wr && host_addr == 3'd1 && !busy && m_g;
    pre_g  = m_g; pa = m_addr; d0 = m_d[0]; d1 = m_d[1];
    if (done) begin
      idx = int'(pa[6:1]);
      if (pa[7]) begin
        if (idx < NREG) m_d[0] = pa[0] ? m_reg[idx][31:16] : m_reg[idx][15:0];
        else m_d[0] = 16'd0;
      end else if (idx < NREG) m_reg[idx] = {d1, d0};
    end
    if (!pre_g) for (int i = 0; i < NREG; i++) m_reg[i] = 32'd0;
    if (abort) m_cnt = 0;
    else if (launch) m_cnt = BUSY;
    else if (m_cnt > 0) m_cnt--;
    if (host_wr) begin
      if (host_addr == 3'd0) begin m_g = host_wdata[1]; m_c = host_wdata[2]; end
      else if (launch) m_addr = host_wdata[7:0];
      else if (host_addr >= 3'd2 && host_addr <= 3'd5 && !busy)
        m_d[host_addr - 3'd2] = host_wdata[15:0];
    end
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_ni) m_reset();
    else m_step();
    #2;
    case (host_addr)
      3'd0: ck("R3 model status", host_rdata_o, m_read(host_addr));
      3'd1: ck("R6 model addr", host_rdata_o, m_read(host_addr));
      3'd6, 3'd7: ck("R11 model unused", host_rdata_o, m_read(host_addr));
      default: ck("R7 model data", host_rdata_o, m_read(host_addr));
    endcase
    ck("R2 model resets", {30'd0, codec_rst_no, glob_rst_no}, {30'd0, m_c, m_g});
  end

  // ---------------- host tasks ----------------
  task automatic hwrite(input logic [2:0] o, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = o; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] o, output logic [31:0] v);
    @(negedge clk);
    host_addr = o;
    #1 v = host_rdata_o;
  endtask

  task automatic wait_idle();
    host_addr = 3'd0;
    for (int k = 0; k < 50; k++) begin
      #1;
      if (!host_rdata_o[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic launch_measure(input logic [7:0] a, output int n);
    hwrite(3'd1, {24'd0, a});
    host_addr = 3'd0;
    n = 0;
    for (int k = 0; k < 20; k++) begin
      #1;
      if (host_rdata_o[0]) n++;
      else break;
      @(negedge clk);
    end
  endtask

  task automatic iwrite32(input logic [5:0] idx, input logic [31:0] v);
    hwrite(3'd2, {16'd0, v[15:0]});
    hwrite(3'd3, {16'd0, v[31:16]});
    hwrite(3'd4, 32'd0);
    hwrite(3'd5, 32'd0);
    hwrite(3'd1, {24'd0, 1'b0, idx, 1'b0});
    wait_idle();
  endtask

  task automatic iread16(input logic [5:0] idx, input logic hi, output logic [31:0] v);
    hwrite(3'd1, {24'd0, 1'b1, idx, hi});
    wait_idle();
    hread(3'd2, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int o = 0; o < 8; o++) begin
      hread(3'(o), v);
      ck("R1 reset read", v, 32'd0);
    end
    ck("R1 reset outputs", {30'd0, codec_rst_no, glob_rst_no}, 32'd0);

    // R2 reset controls
    hwrite(3'd0, 32'h2);
    ck("R2 global only", {30'd0, codec_rst_no, glob_rst_no}, 32'd1);
    hwrite(3'd0, 32'h7);
    hread(3'd0, v);
    ck("R2 busy bit read-only", v, 32'd6);

    // R3 busy length on a write launch
    hwrite(3'd2, 32'h0000_BEEF);
    hwrite(3'd3, 32'h0000_DEAD);
    launch_measure({1'b0, 6'd3, 1'b0}, n);
    ck("R3 busy cycles", 32'(n), 32'(BUSY));

    // R4 half select on reads
    iread16(6'd3, 1'b0, v);
    ck("R4 read low half", v, 32'h0000_BEEF);
    iread16(6'd3, 1'b1, v);
    ck("R4 read high half", v, 32'h0000_DEAD);
    launch_measure({1'b1, 6'd3, 1'b1}, n);
    ck("R3 busy cycles on read", 32'(n), 32'(BUSY));

    // R5 write ignores bit 0
    hwrite(3'd2, 32'h5678);
    hwrite(3'd3, 32'h1234);
    hwrite(3'd1, {24'd0, 1'b0, 6'd5, 1'b1});
    wait_idle();
    iread16(6'd5, 1'b0, v);
    ck("R5 write low", v, 32'h5678);
    iread16(6'd5, 1'b1, v);
    ck("R5 write high", v, 32'h1234);

    // R6 writes while busy are ignored
    hwrite(3'd1, 32'h86);
    hwrite(3'd1, 32'h8E);
    hwrite(3'd2, 32'hAAAA);
    wait_idle();
    hread(3'd1, v);
    ck("R6 address held", v, 32'h86);
    hread(3'd2, v);
    ck("R6 read result kept", v, 32'hBEEF);
    hwrite(3'd2, 32'h1111);
    hwrite(3'd3, 32'h2222);
    hwrite(3'd1, {24'd0, 1'b0, 6'd7, 1'b0});
    hwrite(3'd2, 32'h9999);
    hwrite(3'd3, 32'h8888);
    wait_idle();
    hread(3'd2, v);
    ck("R6 data0 held", v, 32'h1111);
    iread16(6'd7, 1'b1, v);
    ck("R6 operand unchanged", v, 32'h2222);

    // R7 data width and unused data registers
    hwrite(3'd2, 32'hFFFF_ABCD);
    hread(3'd2, v);
    ck("R7 low 16 only", v, 32'h0000_ABCD);
    hwrite(3'd3, 32'h0000_0042);
    hwrite(3'd4, 32'h5555);
    hwrite(3'd5, 32'h6666);
    hwrite(3'd1, {24'd0, 1'b0, 6'd9, 1'b0});
    wait_idle();
    hread(3'd4, v);
    ck("R7 data2 readback", v, 32'h5555);
    iread16(6'd9, 1'b1, v);
    ck("R7 upper from data1", v, 32'h0042);
    iread16(6'd9, 1'b0, v);
    ck("R7 lower from data0", v, 32'hABCD);

    // R8 out-of-range index
    iwrite32(6'd20, 32'hCAFE_F00D);
    iread16(6'd20, 1'b0, v);
    ck("R8 out of range reads 0", v, 32'd0);
    iread16(6'd4, 1'b0, v);
    ck("R8 no aliasing", v, 32'd0);

    // R10 read-modify-write of single bits
    iwrite32(6'd10, 32'h0000_00F0);
    iread16(6'd10, 1'b0, v);
    hwrite(3'd2, v | 32'h0100);
    hwrite(3'd3, 32'd0);
    hwrite(3'd1, {24'd0, 1'b0, 6'd10, 1'b0});
    wait_idle();
    iread16(6'd10, 1'b0, v);
    ck("R10 bit set", v, 32'h01F0);
    hwrite(3'd2, v & ~32'h0010);
    hwrite(3'd3, 32'd0);
    hwrite(3'd1, {24'd0, 1'b0, 6'd10, 1'b0});
    wait_idle();
    iread16(6'd10, 1'b0, v);
    ck("R10 bit clear", v, 32'h01E0);
    iread16(6'd10, 1'b1, v);
    ck("R10 upper untouched", v, 32'd0);

    // R11 unused offsets
    hwrite(3'd6, 32'hFFFF_FFFF);
    hwrite(3'd7, 32'h1234_5678);
    hread(3'd6, v);
    ck("R11 offset 6", v, 32'd0);
    hread(3'd7, v);
    ck("R11 offset 7", v, 32'd0);
    hread(3'd1, v);
    ck("R11 address readback", v, {24'd0, 1'b1, 6'd10, 1'b1});

    // R9 global reset cancels and clears
    hwrite(3'd1, {24'd0, 1'b0, 6'd3, 1'b0});
    hwrite(3'd0, 32'd0);
    hread(3'd0, v);
    ck("R9 abort clears busy", v, 32'd0);
    hwrite(3'd1, 32'h86);
    hread(3'd0, v);
    ck("R9 launch ignored in reset", v, 32'd0);
    hwrite(3'd0, 32'h6);
    iread16(6'd3, 1'b1, v);
    ck("R9 bank cleared", v, 32'd0);
    iread16(6'd5, 1'b0, v);
    ck("R9 bank cleared other", v, 32'd0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule